// File: doc/BRIEF.md
# Next Instruction Address Unit

This block owns the program counter of a simple in-order core. On every cycle where the sequencer raises the advance strobe, it picks the address of the next instruction from a small control code that the decoder supplies. The candidates are the fall-through address, a conditional branch target relative to the current address, a jump target inside the current 256 MB region, and an address taken from a register. Conditional branches compare the two register operands, either for equality or for inequality.

For the call form of the jump, the block also presents a return address and a one-cycle write request for the fixed link register. The register file takes these and applies them. Instruction fetch, delay slots and exceptions are handled outside the block.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 and `link_we` becomes 0.
- R2: With control code 0 (sequential), an advance sets `pc` to the old `pc` plus 4, modulo 2^32. Codes 6 and 7 behave the same way.
- R3: At a rising edge where `adv` is low, `pc` keeps its value.
- R4: With code 1 (branch-if-equal), an advance goes to the branch target when `opa` equals `opb`, and to `pc`+4 otherwise.
- R5: With code 2 (branch-if-different), an advance goes to the branch target when `opa` differs from `opb`, and to `pc`+4 otherwise.
- R6: The branch target is the old `pc` plus 4 plus `imm` sign-extended from 16 bits and multiplied by 4, all modulo 2^32.
- R7: With code 3 (jump), an advance sets `pc` to `{old pc[31:28], tgt[25:0], 2'b00}`. The top four bits never change.
- R8: With code 4 (register jump), an advance sets `pc` to `opa`.
- R9: With code 5 (jump and link), an advance makes the same `pc` change as code 3. In the following cycle, `link_we` is 1, `link_data` holds the old `pc`+4, and `link_idx` is 31.
- R10: `link_we` is 1 only in the cycle right after an advance with code 5. After any other edge it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance strobe; the PC updates only when it is high |
| ctl | input | 3 | Control code: 0 seq, 1 beq, 2 bne, 3 j, 4 jr, 5 jal |
| imm | input | 16 | Branch word offset (signed) |
| tgt | input | 26 | Jump word index |
| opa | input | 32 | First register operand; also the jr target |
| opb | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| link_data | output | 32 | Return address for the link register |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register number (31) |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 16-bit offset and a 26-bit jump index. At these widths the sign bit of the offset, the wrap of the address at 2^32 and the four region bits kept by a jump can all be reached. Register jumps place the PC anywhere, so each branch and jump form can start from a chosen base. A sweep of offsets includes the most negative and most positive values. Further cases cover calls from the top word of the address space and the unused control codes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    NPC_SEQ  = 3'd0,
    NPC_BEQ  = 3'd1,
    NPC_BNE  = 3'd2,
    NPC_JMP  = 3'd3,
    NPC_JREG = 3'd4,
    NPC_JAL  = 3'd5
  } npc_ctl_e;
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            same
);
  always_comb same = (a == b);
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] tgt,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  br_addr,
  output logic [XLEN-1:0]  jmp_addr
);
  localparam int REGION_W = XLEN - TGT_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offs;

  always_comb begin
    seq_addr = pc + XLEN'(4);
    offs     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    br_addr  = seq_addr + offs;
    jmp_addr = {pc[XLEN-1 -: REGION_W], tgt, 2'b00};
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      ctl,
  input  logic            same,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] br_addr,
  input  logic [XLEN-1:0] jmp_addr,
  input  logic [XLEN-1:0] reg_addr,
  output logic [XLEN-1:0] next_addr,
  output logic            is_call
);
  always_comb begin
    next_addr = seq_addr;
    is_call   = 1'b0;
    case (npc_ctl_e'(ctl))
      NPC_BEQ:  if (same)  next_addr = br_addr;
      NPC_BNE:  if (!same) next_addr = br_addr;
      NPC_JMP:  next_addr = jmp_addr;
      NPC_JREG: next_addr = reg_addr;
      NPC_JAL: begin
        next_addr = jmp_addr;
        is_call   = 1'b1;
      end
      default:  next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int TGT_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [2:0]        ctl,
  input  logic [IMM_W-1:0]  imm,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   link_data,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx
);
  localparam int REGION_W = XLEN - TGT_W - 2;

  logic            same;
  logic            is_call;
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr, next_addr;

  npc_cmp #(.XLEN(XLEN)) u_cmp (.a(opa), .b(opb), .same(same));

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
    .pc(pc), .imm(imm), .tgt(tgt),
    .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .ctl(ctl), .same(same), .seq_addr(seq_addr), .br_addr(br_addr),
    .jmp_addr(jmp_addr), .reg_addr(opa),
    .next_addr(next_addr), .is_call(is_call)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      link_we <= adv && is_call;
      if (adv) begin
        pc <= next_addr;
        if (is_call) link_data <= seq_addr;
      end
    end
  end

  assign link_idx = RIDX_W'(LINK_REG);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc));
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && ctl == 3'(NPC_SEQ)) |=> pc == $past(pc) + XLEN'(4));
  assert_region_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && (ctl == 3'(NPC_JMP) || ctl == 3'(NPC_JAL)))
      |=> pc[XLEN-1 -: REGION_W] == $past(pc[XLEN-1 -: REGION_W]));
  assert_link_cause_R10: assert property (@(posedge clk) disable iff (rst)
    link_we |-> ($past(adv) && $past(ctl) == 3'(NPC_JAL)));
  assert_link_value_R9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_data == $past(pc) + XLEN'(4));
endmodule

// File: tb/sim_nextpc_unit.sv
`timescale 1ns/1ps
module sim_nextpc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [2:0]  ctl = 3'd0;
  logic [15:0] imm = '0;
  logic [25:0] tgt = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] pc, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nextpc_unit u0 (
    .clk(clk), .rst(rst), .adv(adv), .ctl(ctl), .imm(imm), .tgt(tgt),
    .opa(opa), .opb(opb), .pc(pc), .link_data(link_data),
    .link_we(link_we), .link_idx(link_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [15:0] i, input logic [25:0] t,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ctl = c; imm = i; tgt = t; opa = a; opb = b; adv = 1'b1;
    @(posedge clk);
    #1 adv = 1'b0;
  endtask

  task automatic setpc(input logic [31:0] v);
    step(3'd4, 16'h0, 26'h0, v, 32'h0);
  endtask

  function automatic logic [31:0] brt(input logic [31:0] p, input logic [15:0] i);
    logic [31:0] sx;
    sx = {{16{i[15]}}, i};
    return p + 32'd4 + sx * 32'd4;
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc", pc, 32'h0);
    check("R1 link_we", {31'b0, link_we}, 32'h0);
    @(negedge clk) rst = 1'b0;

    step(3'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    check("R2 seq", pc, 32'h4);
    check("R10 seq no link", {31'b0, link_we}, 32'h0);

    @(negedge clk) ctl = 3'd4; opa = 32'hDEAD_BEE0;
    repeat (3) @(posedge clk);
    #1 check("R3 hold", pc, 32'h4);

    setpc(32'h1234_5678);
    check("R8 jr", pc, 32'h1234_5678);
    check("R10 jr no link", {31'b0, link_we}, 32'h0);

    setpc(32'hFFFF_FFFC);
    step(3'd0, 16'h0, 26'h0, 32'h0, 32'h0);
    check("R2 wrap", pc, 32'h0);

    setpc(32'h1000_0000);
    step(3'd1, 16'h0003, 26'h0, 32'h55, 32'h55);
    check("R4 beq taken", pc, 32'h1000_0010);
    step(3'd1, 16'h0003, 26'h0, 32'h55, 32'h54);
    check("R4 beq not taken", pc, 32'h1000_0014);
    step(3'd2, 16'hFFFF, 26'h0, 32'h1, 32'h2);
    check("R5 bne taken back", pc, 32'h1000_0014);
    step(3'd2, 16'h0040, 26'h0, 32'h7, 32'h7);
    check("R5 bne not taken", pc, 32'h1000_0018);

    for (int k = 0; k < 70; k++) begin
      logic [15:0] iv;
      case (k)
        0: iv = 16'h0000;
        1: iv = 16'h7FFF;
        2: iv = 16'h8000;
        3: iv = 16'hFFFF;
        default: iv = 16'(k * 1031 + k * k * 97);
      endcase
      base = 32'h4000_0000 + 32'(k) * 32'h0001_0004;
      setpc(base);
      step(3'd1, iv, 26'h0, 32'(k), 32'(k));
      check("R6 branch target", pc, brt(base, iv));
    end

    setpc(32'hA000_0100);
    step(3'd3, 26'h3FF_FFFF, 26'h3FF_FFFF, 32'h0, 32'h0);
    check("R7 jump max", pc, 32'hAFFF_FFFC);
    step(3'd3, 16'h0, 26'h0, 32'h0, 32'h0);
    check("R7 jump zero", pc, 32'hA000_0000);
    check("R10 j no link", {31'b0, link_we}, 32'h0);

    setpc(32'h5000_0020);
    step(3'd5, 16'h0, 26'h10, 32'h0, 32'h0);
    check("R9 jal pc", pc, 32'h5000_0040);
    check("R9 jal we", {31'b0, link_we}, 32'h1);
    check("R9 jal data", link_data, 32'h5000_0024);
    check("R9 jal idx", {27'b0, link_idx}, 32'd31);
    @(posedge clk);
    #1 check("R10 one-cycle we", {31'b0, link_we}, 32'h0);

    setpc(32'hFFFF_FFFC);
    step(3'd5, 16'h0, 26'h1, 32'h0, 32'h0);
    check("R9 jal wrap pc", pc, 32'hF000_0004);
    check("R9 jal wrap link", link_data, 32'h0);

    setpc(32'h0000_0100);
    step(3'd6, 16'h0010, 26'h10, 32'h1, 32'h1);
    check("R2 code6", pc, 32'h104);
    step(3'd7, 16'h0010, 26'h10, 32'h1, 32'h1);
    check("R2 code7", pc, 32'h108);

    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check("R1 mid reset", pc, 32'h0);
    @(negedge clk) rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule